// File: doc/BRIEF.md
# User Data Message Extractor FIFO

This block sits behind a digital audio receiver and takes the one user-data bit carried in each received subframe. It finds where the 8-bit information units start and where whole messages start. It then stores the results in a 128-entry byte queue that a host drains one byte at a time. Each unit begins with a 1 start bit and is sent most significant bit first. Zero bits between units carry no data and are skipped. A run of more than eight zeros separates two messages.

In normal mode each unit becomes one stored byte. Bit 7 of that byte tells the host whether the byte opens a message, so a host that reads in pieces can still find message boundaries. In Q mode only the second bit of each unit is kept. For subcode-style data this is the Q channel. Eight of these bits are packed into one byte, so a 96-unit frame shrinks to 12 bytes. An active-low available flag tells the host when bytes are waiting. When the queue is full, newly finished bytes are thrown away and a sticky overflow flag is raised.

Top module: `ud_msg_fifo`

## Requirements
- R1: After reset `avail_n_o` is 1 (nothing stored), `ovf_o` is 0, and the first unit received is treated as the start of a message.
- R2: In normal mode (`qmode_i`=0), each unit (start bit 1, then seven payload bits sent first to last) is stored as one byte. Byte bits 6..0 hold the payload bits in the order received, with the first payload bit in bit 6. Byte bit 7 is 1 for the first byte of a message and 0 for every later byte of that message.
- R3: Between units of one message, a run of 0 to 8 zero bits keeps the message open, and none of those zeros is stored.
- R4: A run of 9 or more consecutive zero bits ends the message, so the next unit opens a new message (bit 7 set in normal mode).
- R5: A cycle with `bit_vld_i`=0 is ignored whatever `bit_i` holds. It neither adds a bit nor breaks a zero run.
- R6: In Q mode (`qmode_i`=1), only the first payload bit of each unit (the Q bit) is kept. The first Q bit of a group goes to byte bit 7 and later ones follow toward bit 0. One byte is stored per eight units. Packing restarts at every message start, and a partly filled byte from the previous message is discarded.
- R7: A completed byte can be read at the second rising clock edge after the edge that samples the unit's last bit. `avail_n_o` is 0 whenever at least one byte is stored, and it returns to 1 only once the last stored byte has been read.
- R8: `rd_data_o` always shows the oldest stored byte. A rise of `rd_i` at a clock edge while a byte is stored removes that byte, and bytes leave in arrival order. `rd_i` with nothing stored has no effect.
- R9: The queue holds 128 bytes. A byte completed while it is full (and no read happens in that cycle) is discarded, and the stored bytes are left unchanged.
- R10: `ovf_o` goes to 1 when a byte is discarded and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | User-data bit of the current subframe |
| bit_vld_i | input | 1 | Qualifies `bit_i` for one cycle |
| qmode_i | input | 1 | 0 = store whole units, 1 = pack Q bits |
| rd_i | input | 1 | Host read strobe, removes the head byte |
| rd_data_o | output | 8 | Oldest stored byte |
| avail_n_o | output | 1 | 0 while at least one byte is stored |
| ovf_o | output | 1 | Sticky flag: a byte was discarded |

## Verification
A byte becomes visible two rising edges after the edge that takes in its unit's last bit: one edge registers the finished byte in the parser and the next writes it into the queue. The bench drives inputs on falling edges. After a unit's last bit it waits one more falling edge before it compares `avail_n_o` or the head byte, and it also checks that the flag is still high at the first falling edge. A read strobe takes effect at the next rising edge, so the following head byte and the final return of `avail_n_o` to 1 are sampled at the falling edge after that.

// File: rtl/ud_pkg.sv
package ud_pkg;
    // width of one information unit and of one stored byte
    localparam int UNIT_W = 8;
    // payload bits following the start bit
    localparam int PAY_W  = UNIT_W - 1;

    typedef logic [UNIT_W-1:0] ud_byte_t;
endpackage

// File: rtl/ud_unit_parser.sv
module ud_unit_parser
    import ud_pkg::*;
#(
    parameter int GAP_MAX = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_i,
    input  logic     vld_i,
    input  logic     qmode_i,
    output logic     push_o,
    output ud_byte_t byte_o
);
    localparam int ZW = $clog2(GAP_MAX + 2);
    localparam int BW = $clog2(UNIT_W);
    localparam logic [ZW-1:0] ZLIM  = ZW'(GAP_MAX);
    localparam logic [BW-1:0] BLAST = BW'(UNIT_W - 1);

    typedef struct packed {
        logic             in_unit;
        logic [BW-1:0]    bcnt;
        logic [PAY_W-1:0] sh;
        logic [ZW-1:0]    zcnt;
        logic             msg_act;
        logic             first;
        ud_byte_t         qacc;
        logic [BW-1:0]    qcnt;
        logic             push;
        ud_byte_t         pbyte;
    } pst_t;

    pst_t             st_q, st_d;
    logic [PAY_W-1:0] pay_d;
    ud_byte_t         qa_d;
    logic [BW-1:0]    qc_d;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        pay_d     = {st_q.sh[PAY_W-2:0], bit_i};
        qa_d      = st_q.qacc;
        qc_d      = st_q.qcnt;
        if (vld_i) begin
            if (!st_q.in_unit) begin
                if (bit_i) begin
                    // start bit: a new unit begins
                    st_d.in_unit = 1'b1;
                    st_d.bcnt    = BW'(1);
                    st_d.sh      = '0;
                    st_d.zcnt    = '0;
                    st_d.first   = !st_q.msg_act;
                end else begin
                    if (st_q.zcnt <= ZLIM) begin
                        st_d.zcnt = st_q.zcnt + 1'b1;
                    end
                    if (st_q.zcnt >= ZLIM) begin
                        st_d.msg_act = 1'b0;
                    end
                end
            end else begin
                st_d.sh = pay_d;
                if (st_q.bcnt == BLAST) begin
                    st_d.in_unit = 1'b0;
                    st_d.bcnt    = '0;
                    st_d.msg_act = 1'b1;
                    st_d.zcnt    = '0;
                    if (!qmode_i) begin
                        st_d.push  = 1'b1;
                        st_d.pbyte = {st_q.first, pay_d};
                    end else begin
                        if (st_q.first) begin
                            qa_d = '0;
                            qc_d = '0;
                        end
                        qa_d      = {qa_d[UNIT_W-2:0], pay_d[PAY_W-1]};
                        st_d.qacc = qa_d;
                        if (qc_d == BLAST) begin
                            st_d.push  = 1'b1;
                            st_d.pbyte = qa_d;
                            st_d.qcnt  = '0;
                        end else begin
                            st_d.qcnt = qc_d + 1'b1;
                        end
                    end
                end else begin
                    st_d.bcnt = st_q.bcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_o = st_q.push;
    assign byte_o = st_q.pbyte;

    // R5: a byte can only finish on a cycle that carried a qualified bit
    a_r5_push_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> $past(vld_i));

    // R3: a unit cannot be in progress while the zero run is non-zero
    a_r3_no_zeros_in_unit: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.in_unit |-> (st_q.zcnt == '0));
endmodule

// File: rtl/ud_byte_queue.sv
module ud_byte_queue
    import ud_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push_i,
    input  ud_byte_t wdata_i,
    input  logic     rd_i,
    output ud_byte_t rdata_o,
    output logic     avail_n_o,
    output logic     ovf_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);
    localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          ovf;
    } qst_t;

    qst_t     st_q, st_d;
    logic     full, rd_eff, wr_en;
    ud_byte_t mem [DEPTH];

    always_comb begin
        st_d   = st_q;
        full   = (st_q.cnt == CFULL);
        rd_eff = rd_i && (st_q.cnt != '0);
        wr_en  = push_i && (!full || rd_eff);
        if (wr_en) begin
            st_d.wp = (st_q.wp == PLAST) ? '0 : st_q.wp + 1'b1;
        end
        if (rd_eff) begin
            st_d.rp = (st_q.rp == PLAST) ? '0 : st_q.rp + 1'b1;
        end
        if (wr_en && !rd_eff) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (rd_eff && !wr_en) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (push_i && !wr_en) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[st_q.wp] <= wdata_i;
        end
    end

    assign rdata_o   = mem[st_q.rp];
    assign avail_n_o = (st_q.cnt == '0);
    assign ovf_o     = st_q.ovf;

    // R9: occupancy never exceeds the queue size
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CFULL);

    // R10: overflow flag never clears without reset
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R10: overflow only rises after a push into a full queue without a read
    a_r10_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(push_i && full && !rd_i));

    // R7: the queue only becomes empty through a read
    a_r7_empty_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(avail_n_o) |-> $past(rd_i));

    // R8: head byte holds while stored and not read
    a_r8_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!avail_n_o && !rd_i) |=> $stable(rdata_o));
endmodule

// File: rtl/ud_msg_fifo.sv
module ud_msg_fifo
    import ud_pkg::*;
#(
    parameter int DEPTH   = 128,
    parameter int GAP_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              bit_vld_i,
    input  logic              qmode_i,
    input  logic              rd_i,
    output logic [UNIT_W-1:0] rd_data_o,
    output logic              avail_n_o,
    output logic              ovf_o
);
    logic     push;
    ud_byte_t pbyte;

    ud_unit_parser #(
        .GAP_MAX (GAP_MAX)
    ) u_parse (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_i   (bit_i),
        .vld_i   (bit_vld_i),
        .qmode_i (qmode_i),
        .push_o  (push),
        .byte_o  (pbyte)
    );

    ud_byte_queue #(
        .DEPTH (DEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .wdata_i   (pbyte),
        .rd_i      (rd_i),
        .rdata_o   (rd_data_o),
        .avail_n_o (avail_n_o),
        .ovf_o     (ovf_o)
    );
endmodule

// File: tb/sim_ud_msg_fifo.sv
`timescale 1ns/1ps
module sim_ud_msg_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_i = 1'b0;
    logic       bit_vld_i = 1'b0;
    logic       qmode_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       avail_n_o;
    logic       ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    logic [7:0] exp_q[$];
    bit         in_msg = 1'b0;
    logic [7:0] qa = '0;
    int         qn = 0;
    bit         stall_en = 1'b0;

    always #5 clk = ~clk;

    ud_msg_fifo u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_i     (bit_i),
        .bit_vld_i (bit_vld_i),
        .qmode_i   (qmode_i),
        .rd_i      (rd_i),
        .rd_data_o (rd_data_o),
        .avail_n_o (avail_n_o),
        .ovf_o     (ovf_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one qualified bit, optionally preceded by an ignored cycle with random data (R5)
    task automatic step_in(input logic b);
        if (stall_en && ($urandom % 4 == 0)) begin
            bit_vld_i = 1'b0;
            bit_i     = 1'($urandom % 2);
            @(negedge clk);
        end
        bit_vld_i = 1'b1;
        bit_i     = b;
        @(negedge clk);
        bit_vld_i = 1'b0;
        bit_i     = 1'b0;
    endtask

    // gap zeros, start bit, seven payload bits; updates the expected queue
    task automatic send_unit(input int gap, input logic [6:0] lo);
        bit newm;
        for (int i = 0; i < gap; i++) step_in(1'b0);
        step_in(1'b1);
        for (int i = 6; i >= 0; i--) step_in(lo[i]);
        newm   = !in_msg || (gap > 8);
        in_msg = 1'b1;
        if (!qmode_i) begin
            if (exp_q.size() < 128) exp_q.push_back({newm, lo});
        end else begin
            if (newm) begin
                qa = '0;
                qn = 0;
            end
            qa = {qa[6:0], lo[6]};
            qn++;
            if (qn == 8) begin
                if (exp_q.size() < 128) exp_q.push_back(qa);
                qn = 0;
            end
        end
    endtask

    task automatic drain(input string req);
        @(negedge clk);
        while (exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk({req, " R7 avail low"}, 32'(avail_n_o), 32'd0);
            chk({req, " R8 head byte"}, 32'(rd_data_o), 32'(e));
            rd_i = 1'b1;
            @(negedge clk);
            rd_i = 1'b0;
        end
        chk({req, " R7 avail high after last read"}, 32'(avail_n_o), 32'd1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        in_msg = 1'b0;
        qa     = '0;
        qn     = 0;
        exp_q.delete();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R1: reset state
        chk("R1 avail after reset", 32'(avail_n_o), 32'd1);
        chk("R1 ovf after reset", 32'(ovf_o), 32'd0);

        // R7: timing of first byte
        send_unit(0, 7'h2A);
        chk("R7 not yet visible one edge after last bit", 32'(avail_n_o), 32'd1);
        @(negedge clk);
        chk("R7 visible two edges after last bit", 32'(avail_n_o), 32'd0);
        chk("R2 first byte of message has bit 7 set", 32'(rd_data_o), 32'hAA);
        // R3: gaps within message; R4: long gap starts a new one
        send_unit(0, 7'h11);
        send_unit(8, 7'h7F);
        send_unit(3, 7'h00);
        send_unit(9, 7'h55);
        send_unit(1, 7'h0F);
        send_unit(12, 7'h33);
        drain("R2 R3 R4 directed");

        // R8: read with nothing stored
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        @(negedge clk);
        chk("R8 empty read keeps avail high", 32'(avail_n_o), 32'd1);
        chk("R8 empty read no overflow", 32'(ovf_o), 32'd0);
        send_unit(0, 7'h01);
        drain("R8 after empty read");

        // R5 plus random gaps and payloads
        stall_en = 1'b1;
        for (int n = 0; n < 40; n++) begin
            send_unit(int'($urandom % 13), 7'($urandom));
        end
        stall_en = 1'b0;
        drain("R5 R2 R3 R4 random");

        // R6: Q mode, 19 units in one message, then a new 8-unit message
        qmode_i = 1'b1;
        send_unit(10, 7'h40);
        for (int n = 1; n < 19; n++) send_unit(int'($urandom % 9), 7'($urandom));
        send_unit(9, 7'h7F);
        for (int n = 1; n < 8; n++) send_unit(int'($urandom % 9), 7'($urandom));
        chk("R6 Q mode bytes expected", 32'(exp_q.size()), 32'd3);
        drain("R6 Q packing");
        qmode_i = 1'b0;

        // R9 / R10: fill beyond capacity
        send_unit(10, 7'h12);
        for (int n = 1; n < 128; n++) send_unit(0, 7'(n));
        @(negedge clk);
        chk("R10 no overflow at exactly 128", 32'(ovf_o), 32'd0);
        send_unit(0, 7'h66);
        send_unit(0, 7'h67);
        @(negedge clk);
        chk("R10 overflow after drop", 32'(ovf_o), 32'd1);
        chk("R9 stored bytes kept", 32'(exp_q.size()), 32'd128);
        drain("R9 full queue contents");
        chk("R10 overflow sticky after drain", 32'(ovf_o), 32'd1);
        do_reset();
        chk("R10 overflow cleared by reset", 32'(ovf_o), 32'd0);
        chk("R1 first unit after reset opens message", 32'(avail_n_o), 32'd1);
        send_unit(0, 7'h05);
        drain("R1 R2 first after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule